// File: doc/BRIEF.md
# Sleep and Event Wake Controller

This block decides when the core stops and which low-power depth it stops at. It sits beside the interrupt arbiter. It receives the core's wait-for-interrupt (WFI), wait-for-event (WFE) and send-event strobes. It also receives three control bits: deep-sleep select, event-on-new-pending and sleep-on-exit. It reads the low-frequency oscillator status and four arbiter signals: an enabled request is present, a new pending bit was set, a handler was entered, and execution returned to thread level. From these it produces a two-bit power mode and a one-cycle wake pulse.

The controller keeps a one-bit event latch that software cannot read. Any event sets it: a send-event strobe, a handler entry, or a newly pending interrupt while event-on-new-pending is 1. A WFE strobe that finds the latch set, or that arrives together with an event, clears the latch and the core does not sleep. This lets software flush a stale event by issuing send-event followed by WFE.

There are three states. In `ST_RUN` the core is executing. A WFI strobe, or a return to thread level with sleep-on-exit set, moves the block to `ST_WFI`. A WFE strobe with no event present moves it to `ST_WFE`. `ST_WFI` returns to `ST_RUN` only on an enabled request. `ST_WFE` returns to `ST_RUN` on an enabled request or on any event, and that return consumes the latch. When a wake is caused by a newly pending interrupt that is not enabled, no handler follows.

Top module: `slpw_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (run), `wake_o` is 0 and the event latch is clear, so the first WFE strobe puts the core to sleep.
- R2: A WFI strobe in run mode with no enabled request present changes `mode_o` to the selected depth in the next cycle. The mode stays there until a wake.
- R3: The depth is chosen when sleep is entered: deep=0 gives 1 (sleep), deep=1 with the oscillator running gives 2 (deep sleep), and deep=1 with the oscillator stopped gives 3 (stop). Changes to deep or the oscillator status while asleep do not alter `mode_o`.
- R4: An enabled request while asleep, in either kind of sleep, makes `mode_o` 0 and `wake_o` 1 in the next cycle. `wake_o` is high for exactly one cycle.
- R5: While in WFI sleep, events such as a newly pending interrupt with event-on-new-pending set do not wake the core.
- R6: In WFE sleep, a newly pending interrupt with event-on-new-pending=1 wakes the core (mode 0, wake pulse) even when no request is enabled. The wake consumes the latch, so the next WFE sleeps.
- R7: A newly pending interrupt with event-on-new-pending=0 is not an event. It neither wakes WFE sleep nor sets the latch.
- R8: A send-event strobe, a handler entry, or a newly pending interrupt with event-on-new-pending=1 sets the latch. A WFE strobe that finds the latch set, or that arrives in the same cycle as an event, keeps mode 0, gives no wake pulse and clears the latch.
- R9: A return to thread level with sleep-on-exit=1 enters sleep at the selected depth and behaves like WFI. With sleep-on-exit=0 it has no effect.
- R10: A WFI strobe, or a sleep-on-exit return, that arrives while an enabled request is present leaves the core in run mode with no wake pulse.
- R11: When WFI and WFE strobe in the same cycle, WFI wins: the core enters WFI sleep and the event latch is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| sev_i | input | 1 | Send-event strobe |
| deep_i | input | 1 | Deep-sleep select |
| sevonpend_i | input | 1 | New pending interrupts count as events |
| soe_i | input | 1 | Sleep again on return to thread level |
| lfo_run_i | input | 1 | Low-frequency oscillator running |
| irq_req_i | input | 1 | Enabled request present (arbiter) |
| pend_new_i | input | 1 | A pending bit was newly set (arbiter) |
| hdl_enter_i | input | 1 | A handler was entered (arbiter) |
| thread_ret_i | input | 1 | Return to thread level (arbiter) |
| mode_o | output | 2 | 0 run, 1 sleep, 2 deep sleep, 3 stop |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench targets the event latch through the only place it shows, which is whether a WFE strobe sleeps. A latch that never clears would make every WFE return at once. A latch that ignores handler entry or send-event would let a stale-event sequence put the core to sleep. Other cases covered are:
- WFI sleep ignoring events, where a wrong design would wake on them.
- A disabled pending interrupt waking WFE sleep only when event-on-new-pending is set.
- The depth staying fixed after the control bits change while asleep.
- The WFI-over-WFE priority, where a wrong design would consume the latch.
- Sleep-on-exit with a request already present, where a wrong design would sleep and then wake.

// File: rtl/slpw_pkg.sv
package slpw_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_DEEP  = 2'd2,
        MODE_STOP  = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_WFI = 2'd1,
        ST_WFE = 2'd2
    } slp_st_e;

    localparam int unsigned NUM_EVT_SRC = 3;
endpackage

// File: rtl/slpw_depth_sel.sv
module slpw_depth_sel
    import slpw_pkg::*;
(
    input  logic   deep_i,
    input  logic   lfo_run_i,
    output pmode_e depth_o
);
    always_comb begin
        if (!deep_i) begin
            depth_o = MODE_SLEEP;
        end else if (lfo_run_i) begin
            depth_o = MODE_DEEP;
        end else begin
            depth_o = MODE_STOP;
        end
    end

    always_comb begin
        a_r3_never_run: assert (depth_o != MODE_RUN);
    end
endmodule

// File: rtl/slpw_evt_latch.sv
module slpw_evt_latch #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic            clr_i,
    output logic            evt_now_o,
    output logic            latch_o
);
    logic latch_q;

    assign evt_now_o = |src_i;
    assign latch_o   = latch_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            latch_q <= 1'b0;
        end else if (clr_i) begin
            latch_q <= 1'b0;
        end else if (evt_now_o) begin
            latch_q <= 1'b1;
        end
    end

    // R8: an event not being consumed leaves the latch set
    a_r8_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_now_o && !clr_i) |=> latch_q);
    // R8: a consume always empties the latch
    a_r8_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !latch_q);
endmodule

// File: rtl/slpw_fsm.sv
module slpw_fsm
    import slpw_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   wfi_i,
    input  logic   wfe_i,
    input  logic   soe_i,
    input  logic   thread_ret_i,
    input  logic   irq_req_i,
    input  logic   evt_now_i,
    input  logic   evt_latch_i,
    input  pmode_e depth_i,
    output logic   evt_clr_o,
    output pmode_e mode_o,
    output logic   wake_o
);
    slp_st_e st_q, st_d;
    pmode_e  mode_q;
    logic    wake_q;
    logic    go_wfi;

    assign go_wfi = wfi_i || (soe_i && thread_ret_i);

    always_comb begin
        st_d      = st_q;
        evt_clr_o = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (go_wfi) begin
                    if (!irq_req_i) begin
                        st_d = ST_WFI;
                    end
                end else if (wfe_i) begin
                    if (evt_latch_i || evt_now_i) begin
                        evt_clr_o = 1'b1;
                    end else begin
                        st_d = ST_WFE;
                    end
                end
            end
            ST_WFI: begin
                if (irq_req_i) begin
                    st_d = ST_RUN;
                end
            end
            ST_WFE: begin
                if (irq_req_i || evt_now_i) begin
                    st_d      = ST_RUN;
                    evt_clr_o = 1'b1;
                end
            end
            default: begin
                st_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= MODE_RUN;
            wake_q <= 1'b0;
        end else begin
            wake_q <= (st_q != ST_RUN) && (st_d == ST_RUN);
            if (st_q == ST_RUN && st_d != ST_RUN) begin
                mode_q <= depth_i;
            end else if (st_d == ST_RUN) begin
                mode_q <= MODE_RUN;
            end
        end
    end

    assign mode_o = mode_q;
    assign wake_o = wake_q;

    // R4: wake is a single-cycle pulse
    a_r4_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_q |=> !wake_q);
    // R4: wake coincides with run mode
    a_r4_wake_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_q |-> (mode_q == MODE_RUN));
    // R2: WFI without request enters a sleep depth
    a_r2_wfi_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && wfi_i && !irq_req_i) |=> (mode_q != MODE_RUN));
    // R3: depth held for the whole sleep
    a_r3_depth_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q != ST_RUN) && $past(st_q != ST_RUN)) |-> $stable(mode_q));
    // R5: WFI sleep only ends on an enabled request
    a_r5_wfi_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_WFI && !irq_req_i) |=> (st_q == ST_WFI));
endmodule

// File: rtl/slpw_ctrl.sv
module slpw_ctrl
    import slpw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wfi_i,
    input  logic       wfe_i,
    input  logic       sev_i,
    input  logic       deep_i,
    input  logic       sevonpend_i,
    input  logic       soe_i,
    input  logic       lfo_run_i,
    input  logic       irq_req_i,
    input  logic       pend_new_i,
    input  logic       hdl_enter_i,
    input  logic       thread_ret_i,
    output logic [1:0] mode_o,
    output logic       wake_o
);
    logic [NUM_EVT_SRC-1:0] evt_src;
    logic   evt_now, evt_latch, evt_clr;
    pmode_e depth, mode;

    assign evt_src = {hdl_enter_i, pend_new_i && sevonpend_i, sev_i};

    slpw_depth_sel u_depth (
        .deep_i    (deep_i),
        .lfo_run_i (lfo_run_i),
        .depth_o   (depth)
    );

    slpw_evt_latch #(.NSRC(NUM_EVT_SRC)) u_evt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (evt_src),
        .clr_i     (evt_clr),
        .evt_now_o (evt_now),
        .latch_o   (evt_latch)
    );

    slpw_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wfi_i        (wfi_i),
        .wfe_i        (wfe_i),
        .soe_i        (soe_i),
        .thread_ret_i (thread_ret_i),
        .irq_req_i    (irq_req_i),
        .evt_now_i    (evt_now),
        .evt_latch_i  (evt_latch),
        .depth_i      (depth),
        .evt_clr_o    (evt_clr),
        .mode_o       (mode),
        .wake_o       (wake_o)
    );

    assign mode_o = mode;

    // R10: a sleep request with an enabled request present stays in run
    a_r10_req_blocks_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == MODE_RUN && irq_req_i && (wfi_i || (soe_i && thread_ret_i)))
        |=> (mode_o == MODE_RUN && !wake_o));
    // R8: WFE with latch set returns without sleeping
    a_r8_wfe_latched_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == MODE_RUN && !wake_o && wfe_i && !wfi_i && !thread_ret_i && evt_latch)
        |=> (mode_o == MODE_RUN && !wake_o && !evt_latch));
endmodule

// File: tb/sim_slpw_ctrl.sv
module sim_slpw_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi = 0, wfe = 0, sev = 0, deep = 0, sevonpend = 0, soe = 0;
    logic       lfo = 0, irq = 0, pend = 0, hdl = 0, tret = 0;
    logic [1:0] mode;
    logic       wake;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slpw_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe), .sev_i(sev),
        .deep_i(deep), .sevonpend_i(sevonpend), .soe_i(soe), .lfo_run_i(lfo),
        .irq_req_i(irq), .pend_new_i(pend), .hdl_enter_i(hdl),
        .thread_ret_i(tret), .mode_o(mode), .wake_o(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // wake with an enabled request and check the pulse (R4)
    task automatic wake_by_req();
        irq = 1; tick(); irq = 0;
        chk("R4 mode after wake", mode, 0);
        chk("R4 wake pulse", wake, 1);
        tick();
        chk("R4 wake one cycle", wake, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset mode", mode, 0);
        chk("R1 reset wake", wake, 0);
    endtask

    task automatic t_wfe_basic();
        deep = 0;
        wfe = 1; tick(); wfe = 0;
        chk("R1 latch clear so WFE sleeps", mode, 1);
        pend = 1; tick(); pend = 0;
        chk("R7 pend without sevonpend no wake", mode, 1);
        chk("R7 no wake pulse", wake, 0);
        sevonpend = 1; pend = 1; tick(); pend = 0; sevonpend = 0;
        chk("R6 pend event wakes WFE", mode, 0);
        chk("R6 wake pulse", wake, 1);
        tick();
        wfe = 1; tick(); wfe = 0;
        chk("R6 latch consumed, WFE sleeps", mode, 1);
        wake_by_req();
    endtask

    task automatic t_wfi_depth(input logic d, input logic l, input int exp);
        deep = d; lfo = l;
        wfi = 1; tick(); wfi = 0;
        chk("R2 WFI enters sleep", mode, exp);
        chk("R3 depth at entry", mode, exp);
        deep = ~d; lfo = ~l; tick();
        chk("R3 depth held", mode, exp);
        sevonpend = 1; pend = 1; tick(); pend = 0; sevonpend = 0;
        chk("R5 event ignored in WFI", mode, exp);
        chk("R5 no wake pulse", wake, 0);
        wake_by_req();
        // the pending event above set the latch; flush it
        wfe = 1; tick(); wfe = 0;
        chk("R8 WFE after event returns", mode, 0);
    endtask

    task automatic t_latch();
        deep = 0;
        sev = 1; tick(); sev = 0;
        wfe = 1; tick(); wfe = 0;
        chk("R8 sev then WFE stays run", mode, 0);
        chk("R8 no wake pulse", wake, 0);
        wfe = 1; tick(); wfe = 0;
        chk("R8 latch cleared, WFE sleeps", mode, 1);
        wake_by_req();
        hdl = 1; tick(); hdl = 0;
        wfe = 1; tick(); wfe = 0;
        chk("R8 handler entry sets latch", mode, 0);
        sevonpend = 1; pend = 1; tick(); pend = 0; sevonpend = 0;
        wfe = 1; tick(); wfe = 0;
        chk("R8 pending event sets latch", mode, 0);
        pend = 1; tick(); pend = 0;
        wfe = 1; tick(); wfe = 0;
        chk("R7 pend without sevonpend not latched", mode, 1);
        wake_by_req();
        sev = 1; wfe = 1; tick(); sev = 0; wfe = 0;
        chk("R8 same-cycle event returns", mode, 0);
        wfe = 1; tick(); wfe = 0;
        chk("R8 same-cycle event consumed", mode, 1);
        wake_by_req();
    endtask

    task automatic t_soe();
        deep = 1; lfo = 1;
        soe = 1; tret = 1; tick(); tret = 0;
        chk("R9 sleep-on-exit enters deep sleep", mode, 2);
        wake_by_req();
        soe = 0; tret = 1; tick(); tret = 0;
        chk("R9 return without sleep-on-exit runs", mode, 0);
        soe = 1; irq = 1; tret = 1; tick(); tret = 0; irq = 0;
        chk("R10 return with request runs", mode, 0);
        chk("R10 no wake pulse", wake, 0);
        soe = 0;
        irq = 1; wfi = 1; tick(); wfi = 0; irq = 0;
        chk("R10 WFI with request runs", mode, 0);
        chk("R10 WFI no wake pulse", wake, 0);
    endtask

    task automatic t_prio();
        deep = 0;
        sev = 1; tick(); sev = 0;
        wfi = 1; wfe = 1; tick(); wfi = 0; wfe = 0;
        chk("R11 WFI wins over WFE", mode, 1);
        wake_by_req();
        wfe = 1; tick(); wfe = 0;
        chk("R11 latch untouched by WFI", mode, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wfe_basic();
        t_wfi_depth(1'b0, 1'b1, 1);
        t_wfi_depth(1'b1, 1'b1, 2);
        t_wfi_depth(1'b1, 1'b0, 3);
        t_latch();
        t_soe();
        t_prio();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule